// File: doc/BRIEF.md
# Quad Converter Serial Register Interface

This block is the digital front end of a four-channel converter. A host writes codes over a three-wire serial bus made of data in, an active-low chip select and a serial clock. Each frame carries a channel address and a code. The addressed channel's staging register takes the code. One shared load strobe, which acts on its level, then copies all four staging registers into the output registers at once. The four output codes drive the converters. A serial output repeats the shifted bits 18 clocks later, so several devices can share one bus in a chain.

The serial pins, the load strobe, the reset strobe and the reset-value select all pass through a synchronizer into the system clock domain. The block detects serial clock edges by oversampling, so the system clock must run at least four times faster than the serial clock. Two resets act on the registers. A power-on reset clears everything to zero. A reset strobe forces every register to zero-scale or to half-scale, depending on the select pin.

Top module: `qdac_serial_if`

## Requirements
- R1: A frame is 18 serial clock rising edges with chip select low, sent MSB first. The first two bits are the channel address, followed by 16 code bits. Address value n (0 to 3) selects channel n, and channel n appears on `dac_code_o[16n+15:16n]`.
- R2: A complete frame updates only the staging register, when chip select rises. The output codes stay unchanged until a load.
- R3: A frame changes only the staging register of the channel it addresses. The other three keep their contents.
- R4: While `ldac_n_i` is low, all four outputs follow their staging registers, including codes written during that time.
- R5: A frame of fewer than 18 clocks writes nothing. A frame of more than 18 clocks uses the last 18 bits received.
- R6: While `rs_n_i` is low, every staging and output register holds 0x0000 if `mid_sel_i` is 0, or 0x8000 if it is 1.
- R7: When `rs_n_i` and `ldac_n_i` are low together, the reset value wins over the load.
- R8: While `por_n` is low, and right after it is released, every register is 0x0000, whatever `mid_sel_i` is.
- R9: `sdo_o` changes only on serial clock falling edges with chip select low. After the Nth falling edge it shows the bit that entered at rising edge N-17.
- R10: Serial clock edges while chip select is high shift nothing and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for oversampling, at least 4x the serial clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out for chaining |
| ldac_n_i | input | 1 | Load strobe, active low, acts on its level |
| rs_n_i | input | 1 | Reset strobe, active low |
| mid_sel_i | input | 1 | Reset value select: 0 gives zero-scale, 1 gives half-scale |
| dac_code_o | output | 64 | Four output codes, channel 0 in the low 16 bits |

## Verification
A staging register that holds a wrong value stays hidden until the next load. At that point every output copies it within four system clocks, so the bench always pulses the load strobe before it checks a write. A shift register that shifted by mistake, or a bit counter that went wrong, shows up in two ways. The next write lands on the wrong channel or with a shifted code. The serial output is also out of step with what was sent, on the falling edges of the next frame. A reset priority that is wrong is visible for one system clock only, so the bench samples exactly three edges after the strobes change.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef struct packed {
      logic sclk;
      logic cs_n;
      logic sdi;
      logic ldac_n;
      logic rs_n;
      logic mid_sel;
   } qdac_pins_t;

   localparam int PINS_W = $bits(qdac_pins_t);

   localparam qdac_pins_t PINS_IDLE = '{
      sclk:    1'b0,
      cs_n:    1'b1,
      sdi:     1'b0,
      ldac_n:  1'b1,
      rs_n:    1'b1,
      mid_sel: 1'b0
   };

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx #(
   parameter int FRAME_W = 18
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   output logic               sdo,
   output logic               sclk_fall,
   output logic               frame_stb,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int              CNT_W    = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic               sclk_q;
   logic               cs_q;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic               sclk_rise;
   logic               cs_rise;
   logic               cs_fall;

   assign sclk_rise = sclk & ~sclk_q;
   assign sclk_fall = ~sclk & sclk_q;
   assign cs_rise   = cs_n & ~cs_q;
   assign cs_fall   = ~cs_n & cs_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sclk_q    <= 1'b0;
         cs_q      <= 1'b1;
         shreg     <= '0;
         cnt       <= '0;
         sdo       <= 1'b0;
         frame_stb <= 1'b0;
      end else begin
         sclk_q    <= sclk;
         cs_q      <= cs_n;
         frame_stb <= cs_rise && (cnt == CNT_FULL);
         if (cs_fall) begin
            cnt <= '0;
         end else if (sclk_rise && !cs_n) begin
            shreg <= {shreg[FRAME_W-2:0], sdi};
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
         end
         if (sclk_fall && !cs_n) sdo <= shreg[FRAME_W-1];
      end
   end

   assign frame_word = shreg;

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 16,
   parameter int WORD_W = 16,
   parameter int ADDR_W = 2
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     wr_stb,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [WORD_W-1:0]        wr_word,
   input  logic                     load_act,
   input  logic                     rst_act,
   input  logic                     rst_mid,
   output logic [NUM_CH-1:0]        wr_sel,
   output logic [NUM_CH*CODE_W-1:0] in_flat,
   output logic [NUM_CH*CODE_W-1:0] dac_flat
);

   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] wr_code;
   logic [CODE_W-1:0] rst_code;

   generate
      if (CODE_W == WORD_W) begin : g_full_code
         assign wr_code = wr_word;
      end else begin : g_narrow_code
         assign wr_code = wr_word[CODE_W-1:0];
      end
   endgenerate

   assign rst_code = rst_mid ? MID_CODE : '0;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [CODE_W-1:0] in_q;
         logic [CODE_W-1:0] dac_q;

         assign wr_sel[ch] = wr_stb && (wr_addr == ADDR_W'(ch));

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               in_q  <= '0;
               dac_q <= '0;
            end else if (rst_act) begin
               in_q  <= rst_code;
               dac_q <= rst_code;
            end else begin
               if (wr_sel[ch]) in_q  <= wr_code;
               if (load_act)   dac_q <= in_q;
            end
         end

         assign in_flat[ch*CODE_W +: CODE_W]  = in_q;
         assign dac_flat[ch*CODE_W +: CODE_W] = dac_q;
      end
   endgenerate

endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
   import qdac_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 16,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     sclk_i,
   input  logic                     cs_n_i,
   input  logic                     sdi_i,
   output logic                     sdo_o,
   input  logic                     ldac_n_i,
   input  logic                     rs_n_i,
   input  logic                     mid_sel_i,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o
);

   localparam int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int FRAME_W = ADDR_W + WORD_W;

   generate
      if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
         $error("qdac_serial_if: NUM_CH out of range");
      end
      if (CODE_W < 2 || CODE_W > WORD_W) begin : g_bad_code
         $error("qdac_serial_if: CODE_W must be 2..WORD_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("qdac_serial_if: SYNC_STAGES must be at least 2");
      end
   endgenerate

   qdac_pins_t               pins_raw;
   qdac_pins_t               pins_s;
   logic                     sclk_fall;
   logic                     frame_stb;
   logic [FRAME_W-1:0]       frame_word;
   logic                     load_act;
   logic                     rst_act;
   logic [NUM_CH-1:0]        wr_sel;
   logic [NUM_CH*CODE_W-1:0] in_flat;

   assign pins_raw = '{
      sclk:    sclk_i,
      cs_n:    cs_n_i,
      sdi:     sdi_i,
      ldac_n:  ldac_n_i,
      rs_n:    rs_n_i,
      mid_sel: mid_sel_i
   };

   qdac_sync #(
      .W       (PINS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) i_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   qdac_serial_rx #(
      .FRAME_W (FRAME_W)
   ) i_rx (
      .clk        (clk),
      .por_n      (por_n),
      .sclk       (pins_s.sclk),
      .cs_n       (pins_s.cs_n),
      .sdi        (pins_s.sdi),
      .sdo        (sdo_o),
      .sclk_fall  (sclk_fall),
      .frame_stb  (frame_stb),
      .frame_word (frame_word)
   );

   assign load_act = ~pins_s.ldac_n;
   assign rst_act  = ~pins_s.rs_n;

   qdac_chan_bank #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W),
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) i_bank (
      .clk      (clk),
      .por_n    (por_n),
      .wr_stb   (frame_stb),
      .wr_addr  (frame_word[FRAME_W-1 -: ADDR_W]),
      .wr_word  (frame_word[WORD_W-1:0]),
      .load_act (load_act),
      .rst_act  (rst_act),
      .rst_mid  (pins_s.mid_sel),
      .wr_sel   (wr_sel),
      .in_flat  (in_flat),
      .dac_flat (dac_code_o)
   );

endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 16
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     rst_act,
   input  logic                     load_act,
   input  logic                     rst_mid,
   input  logic                     frame_stb,
   input  logic                     sclk_fall,
   input  logic                     sdo,
   input  logic [NUM_CH-1:0]        wr_sel,
   input  logic [NUM_CH*CODE_W-1:0] in_flat,
   input  logic [NUM_CH*CODE_W-1:0] dac_flat
);

   logic [CODE_W-1:0] exp_rst;
   assign exp_rst = rst_mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

   AST_WR_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(wr_sel)); // R3

   AST_IN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!frame_stb && !rst_act) |=> $stable(in_flat)); // R5

   AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!por_n)
      !sclk_fall |=> $stable(sdo)); // R9

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         AST_RESET_CODE: assert property (@(posedge clk) disable iff (!por_n)
            rst_act |=> dac_flat[ch*CODE_W +: CODE_W] == $past(exp_rst)); // R6

         AST_RESET_WINS: assert property (@(posedge clk) disable iff (!por_n)
            (rst_act && load_act) |=> in_flat[ch*CODE_W +: CODE_W] == dac_flat[ch*CODE_W +: CODE_W]); // R7

         AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!por_n)
            (load_act && !rst_act) |=> dac_flat[ch*CODE_W +: CODE_W] == $past(in_flat[ch*CODE_W +: CODE_W])); // R4

         AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!por_n)
            (!load_act && !rst_act) |=> $stable(dac_flat[ch*CODE_W +: CODE_W])); // R2
      end
   endgenerate

endmodule

bind qdac_serial_if qdac_serial_if_chk #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W)
) i_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_act   (rst_act),
   .load_act  (load_act),
   .rst_mid   (pins_s.mid_sel),
   .frame_stb (frame_stb),
   .sclk_fall (sclk_fall),
   .sdo       (sdo_o),
   .wr_sel    (wr_sel),
   .in_flat   (in_flat),
   .dac_flat  (dac_code_o)
);

// File: tb/test_qdac_serial_if.sv
module test_qdac_serial_if;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic        ldac_n = 1'b1;
   logic        rs_n = 1'b1;
   logic        mid_sel = 1'b0;
   logic        sdo;
   logic [63:0] dac;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [63:0] hist;
   logic [15:0] exp_ch [4];

   always #2 clk = ~clk;

   qdac_serial_if i_qdac_serial_if (
      .clk        (clk),
      .por_n      (por_n),
      .sclk_i     (sclk),
      .cs_n_i     (cs_n),
      .sdi_i      (sdi),
      .sdo_o      (sdo),
      .ldac_n_i   (ldac_n),
      .rs_n_i     (rs_n),
      .mid_sel_i  (mid_sel),
      .dac_code_o (dac)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ch_of(input int ch);
      return dac[ch*16 +: 16];
   endfunction

   task automatic check_all(input string req);
      for (int ch = 0; ch < 4; ch++)
         check(ch_of(ch) == exp_ch[ch], req, 64'(ch_of(ch)), 64'(exp_ch[ch]));
   endtask

   // Sends the n low bits of seq, MSB first; hist[k] holds sdo after fall k.
   task automatic send_bits(input int n, input logic [63:0] seq);
      cs_n = 1'b0;
      wait_clk(4);
      hist = '0;
      for (int k = 1; k <= n; k++) begin
         sdi = seq[n-k];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
         hist[k] = sdo;
      end
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic send_frame(input int ch, input logic [15:0] code);
      send_bits(18, {46'd0, 2'(ch), code});
   endtask

   task automatic pulse_load;
      ldac_n = 1'b0;
      wait_clk(6);
      ldac_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic t_reset;
      for (int ch = 0; ch < 4; ch++) exp_ch[ch] = 16'h0000;
      check_all("R8 reset state");
      check(sdo == 1'b0, "R8 sdo reset", 64'(sdo), 64'd0);
   endtask

   task automatic t_write_then_load;
      send_frame(0, 16'h1234);
      send_frame(1, 16'hABCD);
      send_frame(2, 16'h0F0F);
      send_frame(3, 16'hFFFF);
      check_all("R2 no output change before load");
      pulse_load();
      exp_ch[0] = 16'h1234; exp_ch[1] = 16'hABCD;
      exp_ch[2] = 16'h0F0F; exp_ch[3] = 16'hFFFF;
      check_all("R1 R4 load of four channels");
   endtask

   task automatic t_decode;
      send_frame(2, 16'h5555);
      pulse_load();
      exp_ch[2] = 16'h5555;
      check_all("R3 only channel 2 changes");
   endtask

   task automatic t_short_frame;
      send_bits(10, {54'd0, 2'd1, 8'h01});
      pulse_load();
      check_all("R5 short frame ignored");
   endtask

   task automatic t_long_frame;
      logic [63:0] seq;
      bit ok;
      seq = {28'd0, 2'd0, 16'hDEAD, 2'd3, 16'h2468};
      send_bits(36, seq);
      ok = 1'b1;
      for (int j = 18; j <= 36; j++)
         if (hist[j] != seq[36-(j-17)]) ok = 1'b0;
      check(ok, "R9 sdo delayed by 18 clocks", hist, seq);
      pulse_load();
      exp_ch[3] = 16'h2468;
      check_all("R5 long frame keeps last 18 bits");
   endtask

   task automatic t_stray_clocks;
      logic [17:0] f1;
      bit ok;
      f1 = {2'd1, 16'hC000};
      send_frame(1, 16'hC000);
      sdi = 1'b1;
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1; wait_clk(4);
         sclk = 1'b0; wait_clk(4);
      end
      sdi = 1'b0;
      send_frame(1, 16'h0042);
      ok = 1'b1;
      for (int k = 1; k <= 17; k++)
         if (hist[k] != f1[17-k]) ok = 1'b0;
      check(ok, "R10 R9 stray clocks shift nothing", hist, 64'(f1));
      pulse_load();
      exp_ch[1] = 16'h0042;
      check_all("R10 frame after stray clocks");
   endtask

   task automatic t_load_held;
      ldac_n = 1'b0;
      wait_clk(6);
      send_frame(0, 16'h7777);
      exp_ch[0] = 16'h7777;
      check_all("R4 outputs follow while load held");
      ldac_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic t_reset_strobe;
      mid_sel = 1'b0;
      wait_clk(6);
      rs_n = 1'b0;
      wait_clk(6);
      rs_n = 1'b1;
      wait_clk(6);
      for (int ch = 0; ch < 4; ch++) exp_ch[ch] = 16'h0000;
      check_all("R6 zero-scale reset");
      send_frame(1, 16'h1111);
      pulse_load();
      exp_ch[1] = 16'h1111;
      mid_sel = 1'b1;
      wait_clk(6);
      rs_n = 1'b0;
      wait_clk(6);
      for (int ch = 0; ch < 4; ch++) exp_ch[ch] = 16'h8000;
      check_all("R6 half-scale during reset");
      rs_n = 1'b1;
      wait_clk(6);
      pulse_load();
      check_all("R6 staging registers hold half-scale");
      mid_sel = 1'b0;
      wait_clk(6);
   endtask

   task automatic t_priority;
      send_frame(2, 16'h3C3C);
      pulse_load();
      exp_ch[2] = 16'h3C3C;
      check_all("R7 setup");
      rs_n = 1'b0;
      ldac_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int ch = 0; ch < 4; ch++) exp_ch[ch] = 16'h0000;
      check_all("R7 reset wins over load");
      rs_n = 1'b1;
      ldac_n = 1'b1;
      wait_clk(6);
   endtask

   task automatic t_power_on;
      send_frame(0, 16'h0AAA);
      pulse_load();
      mid_sel = 1'b1;
      wait_clk(6);
      por_n = 1'b0;
      wait_clk(3);
      for (int ch = 0; ch < 4; ch++) exp_ch[ch] = 16'h0000;
      check_all("R8 power-on reset during");
      por_n = 1'b1;
      wait_clk(6);
      check_all("R8 power-on reset after release");
      mid_sel = 1'b0;
      wait_clk(6);
   endtask

   initial begin
      wait_clk(5);
      por_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_write_then_load();
      t_decode();
      t_short_frame();
      t_long_frame();
      t_stray_clocks();
      t_load_held();
      t_reset_strobe();
      t_priority();
      t_power_on();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule